// File: doc/BRIEF.md
# Shift-Add All-Pass Half-Band Filter

This block is a recursive half-band filter with fixed coefficients. Its corner sits at one quarter of the sample rate. Two first-order all-pass sections in z² work side by side. One section takes each incoming sample directly. The other takes the same stream one sample later. Halving the sum of the two section outputs gives a low-pass result. Halving their difference gives the complementary high-pass result. Both come from the same pair of sections, so the block suits decimation stages and two-band splitters.

No coefficient uses a multiplier. Each coefficient is the signed sum of at most three arithmetic right shifts of the operand. The internal datapath carries fraction bits below the input LSB and guard bits above the input MSB. Both outputs are rounded to nearest and clipped to the output width. A clock-enable input freezes the whole datapath when it is low, which lets the block run at a lower sample rate inside a faster clock domain.

Top module: `hb_allpass_halfband`

## Requirements
- R1: When `rst` is high at a rising edge, every register, including both outputs, becomes zero whatever `ce` is. After that, while `din` stays zero, both outputs stay zero.
- R2: A sample on `din` is captured at one enabled edge. It first affects the outputs after the next enabled edge, so the latency is two enabled edges.
- R3: The internal value of a sample is its sign-extended input shifted left by FRAC = 8 bits. Branch 0 takes the newest captured sample and uses the coefficient 2⁻² + 2⁻⁵. Branch 1 takes the sample one step older and uses 2⁻¹ + 2⁻³ + 2⁻⁶. Each term is an arithmetic (floor) right shift. Each branch computes y[n] = c·(u[n] − y[n−2]) + u[n−2].
- R4: After a constant input has been applied long enough, `lp_out` is within 2 LSB of that input and `hp_out` is within 2 LSB of zero.
- R5: After an input that alternates between +32767 and −32767 has been applied long enough, `lp_out` is within 2 LSB of zero and `|hp_out|` is at least 32760.
- R6: Each output equals floor((s + 2^FRAC) / 2^(FRAC+1)). Here s is the branch sum for `lp_out` and the branch-0-minus-branch-1 difference for `hp_out`, so halves round upward.
- R7: A rounded value above 2^(OUT_W−1)−1 is output as 2^(OUT_W−1)−1. A rounded value below −2^(OUT_W−1) is output as −2^(OUT_W−1).
- R8: With USE_CE = 1, an edge where `ce` is low, and `rst` is low, changes no register. The outputs hold, and the later sequence is the same as if that edge had not happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear of all registers, active high |
| ce | input | 1 | Advance enable; when low, all state holds (used when USE_CE = 1) |
| din | input | IN_W | Two's-complement input sample |
| lp_out | output | OUT_W | Rounded, saturated low-pass output |
| hp_out | output | OUT_W | Rounded, saturated complementary high-pass output |

## Verification
A sample presented before enabled edge k is registered at edge k. It enters both all-pass sections combinationally and reaches the output registers at the next enabled edge. Edges with `ce` low shift this schedule without changing it. The bench drives inputs at the falling edge and advances its own shift-add model only on edges where the block advances. It compares both outputs one time unit after each rising edge. The two-edge latency itself is checked directly: after the first sample of an impulse is captured the outputs are still zero, and they move only after the following edge.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int TERMS = 3;

    // One shifted copy of the operand inside a constant multiply.
    typedef struct packed {
        logic       en;
        logic       neg;
        logic [4:0] sh;
    } csd_term_t;

    typedef csd_term_t [TERMS-1:0] csd_coef_t;

    localparam csd_term_t TERM_OFF = '{en: 1'b0, neg: 1'b0, sh: 5'd0};

    // 0.28125 = 2^-2 + 2^-5
    localparam csd_coef_t COEF_B0_DEF = {
        TERM_OFF,
        csd_term_t'{en: 1'b1, neg: 1'b0, sh: 5'd5},
        csd_term_t'{en: 1'b1, neg: 1'b0, sh: 5'd2}
    };

    // 0.640625 = 2^-1 + 2^-3 + 2^-6
    localparam csd_coef_t COEF_B1_DEF = {
        csd_term_t'{en: 1'b1, neg: 1'b0, sh: 5'd6},
        csd_term_t'{en: 1'b1, neg: 1'b0, sh: 5'd3},
        csd_term_t'{en: 1'b1, neg: 1'b0, sh: 5'd1}
    };

endpackage

// File: rtl/hb_csd_mul.sv
module hb_csd_mul #(
    parameter int                W    = 27,
    parameter hb_pkg::csd_coef_t COEF = hb_pkg::COEF_B0_DEF
) (
    input  logic signed [W-1:0] operand,
    output logic signed [W-1:0] product
);

    logic signed [W-1:0] term [hb_pkg::TERMS];

    for (genvar t = 0; t < hb_pkg::TERMS; t++) begin : g_term
        if (COEF[t].en) begin : g_on
            if (COEF[t].neg) begin : g_sub
                assign term[t] = -(operand >>> COEF[t].sh);
            end else begin : g_add
                assign term[t] = operand >>> COEF[t].sh;
            end
        end else begin : g_off
            assign term[t] = '0;
        end
    end

    always_comb begin
        product = '0;
        for (int t = 0; t < hb_pkg::TERMS; t++) begin
            product = product + term[t];
        end
    end

endmodule

// File: rtl/hb_ap_section.sv
module hb_ap_section #(
    parameter int                W    = 27,
    parameter hb_pkg::csd_coef_t COEF = hb_pkg::COEF_B0_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv,
    input  logic signed [W-1:0] x_now,
    input  logic signed [W-1:0] x_old2,
    output logic signed [W-1:0] y_now
);

    typedef struct packed {
        logic signed [W-1:0] y1;
        logic signed [W-1:0] y2;
    } ap_state_t;

    ap_state_t           st_d, st_q;
    logic signed [W-1:0] diff_w;
    logic signed [W-1:0] scaled_w;

    assign diff_w = x_now - st_q.y2;

    hb_csd_mul #(.W(W), .COEF(COEF)) u_mul (
        .operand (diff_w),
        .product (scaled_w)
    );

    always_comb begin
        y_now = scaled_w + x_old2;
        st_d  = st_q;
        if (adv) begin
            st_d.y1 = y_now;
            st_d.y2 = st_q.y1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/hb_out_round.sv
module hb_out_round #(
    parameter int SW    = 28,
    parameter int FRAC  = 8,
    parameter int OUT_W = 16
) (
    input  logic signed [SW-1:0]    acc,
    output logic signed [OUT_W-1:0] q
);

    localparam int EW = SW + 1;
    localparam int RW = EW - (FRAC + 1);
    localparam logic signed [RW-1:0] HI = RW'((longint'(1) <<< (OUT_W - 1)) - 1);
    localparam logic signed [RW-1:0] LO = RW'(-(longint'(1) <<< (OUT_W - 1)));

    logic signed [EW-1:0] biased;
    logic signed [RW-1:0] shifted;

    always_comb begin
        biased  = EW'(acc) + (EW'(1) <<< FRAC);
        shifted = RW'(biased >>> (FRAC + 1));
        if (shifted > HI)      q = HI[OUT_W-1:0];
        else if (shifted < LO) q = LO[OUT_W-1:0];
        else                   q = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/hb_allpass_halfband.sv
module hb_allpass_halfband #(
    parameter int                IN_W    = 16,
    parameter int                OUT_W   = 16,
    parameter int                FRAC    = 8,
    parameter int                GUARD   = 3,
    parameter bit                USE_CE  = 1'b1,
    parameter hb_pkg::csd_coef_t COEF_B0 = hb_pkg::COEF_B0_DEF,
    parameter hb_pkg::csd_coef_t COEF_B1 = hb_pkg::COEF_B1_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] lp_out,
    output logic signed [OUT_W-1:0] hp_out
);

    localparam int W  = IN_W + GUARD + FRAC;
    localparam int SW = W + 1;
    localparam int NB = 2;

    if (OUT_W > IN_W + 3) begin : g_bad_out_w
        $error("OUT_W may exceed IN_W by at most three bits");
    end
    if (GUARD < 3) begin : g_bad_guard
        $error("GUARD must be at least 3 bits");
    end

    typedef struct packed {
        logic signed [IN_W-1:0]  x0;
        logic signed [IN_W-1:0]  x1;
        logic signed [IN_W-1:0]  x2;
        logic signed [IN_W-1:0]  x3;
        logic signed [OUT_W-1:0] lp;
        logic signed [OUT_W-1:0] hp;
    } hb_state_t;

    hb_state_t               st_d, st_q;
    logic                    adv;
    logic signed [W-1:0]     xw [4];
    logic signed [W-1:0]     br_now [NB];
    logic signed [W-1:0]     br_old [NB];
    logic signed [W-1:0]     br_y   [NB];
    logic signed [SW-1:0]    acc    [NB];
    logic signed [OUT_W-1:0] rnd    [NB];

    assign adv = USE_CE ? ce : 1'b1;

    always_comb begin
        xw[0] = W'(st_q.x0) <<< FRAC;
        xw[1] = W'(st_q.x1) <<< FRAC;
        xw[2] = W'(st_q.x2) <<< FRAC;
        xw[3] = W'(st_q.x3) <<< FRAC;
    end

    // Polyphase split: branch b sees the input delayed by b samples.
    for (genvar b = 0; b < NB; b++) begin : g_branch
        assign br_now[b] = xw[b];
        assign br_old[b] = xw[b + 2];

        hb_ap_section #(
            .W    (W),
            .COEF ((b == 0) ? COEF_B0 : COEF_B1)
        ) u_sec (
            .clk    (clk),
            .rst    (rst),
            .adv    (adv),
            .x_now  (br_now[b]),
            .x_old2 (br_old[b]),
            .y_now  (br_y[b])
        );
    end

    assign acc[0] = SW'(br_y[0]) + SW'(br_y[1]);
    assign acc[1] = SW'(br_y[0]) - SW'(br_y[1]);

    for (genvar o = 0; o < NB; o++) begin : g_out
        hb_out_round #(
            .SW    (SW),
            .FRAC  (FRAC),
            .OUT_W (OUT_W)
        ) u_rnd (
            .acc (acc[o]),
            .q   (rnd[o])
        );
    end

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.x0 = din;
            st_d.x1 = st_q.x0;
            st_d.x2 = st_q.x1;
            st_d.x3 = st_q.x2;
            st_d.lp = rnd[0];
            st_d.hp = rnd[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lp_out = st_q.lp;
    assign hp_out = st_q.hp;

endmodule

// File: rtl/hb_allpass_halfband_chk.sv
module hb_allpass_halfband_chk #(
    parameter int IN_W   = 16,
    parameter int OUT_W  = 16,
    parameter bit USE_CE = 1'b1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ce,
    input logic signed [IN_W-1:0]  din,
    input logic signed [OUT_W-1:0] lp_out,
    input logic signed [OUT_W-1:0] hp_out
);

    logic quiet_q;

    // High while din has been zero at every edge since the last reset.
    always_ff @(posedge clk) begin
        if (rst)            quiet_q <= 1'b1;
        else if (din != '0) quiet_q <= 1'b0;
    end

    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lp_out == '0 && hp_out == '0));

    a_r1_silence: assert property (@(posedge clk) disable iff (rst)
        quiet_q |-> (lp_out == '0 && hp_out == '0));

    a_r2_two_edge_latency: assert property (@(posedge clk) disable iff (rst)
        $past(rst, 2) |-> (lp_out == '0 && hp_out == '0));

    if (USE_CE) begin : g_ce
        a_r8_hold: assert property (@(posedge clk) disable iff (rst)
            !ce |=> ($stable(lp_out) && $stable(hp_out)));
    end

endmodule

bind hb_allpass_halfband hb_allpass_halfband_chk #(
    .IN_W   (IN_W),
    .OUT_W  (OUT_W),
    .USE_CE (USE_CE)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .din    (din),
    .lp_out (lp_out),
    .hp_out (hp_out)
);

// File: tb/hb_allpass_halfband_bench.sv
`timescale 1ns/1ps
module hb_allpass_halfband_bench;

    localparam int IN_W  = 16;
    localparam int OUT_W = 16;
    localparam int FRAC  = 8;
    localparam longint FS = 32767;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    ce  = 1'b1;
    logic signed [IN_W-1:0]  din = '0;
    logic signed [OUT_W-1:0] lp_out;
    logic signed [OUT_W-1:0] hp_out;

    int n_checks = 0;
    int n_fail   = 0;
    int clip_seen = 0;
    bit done = 1'b0;

    // model state
    longint m_x [4];
    longint m_y [2][2];
    longint e_lp = 0;
    longint e_hp = 0;

    always #2 clk = ~clk;

    hb_allpass_halfband u_hb_allpass_halfband (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .din    (din),
        .lp_out (lp_out),
        .hp_out (hp_out)
    );

    function automatic longint coef_mul(int b, longint v);
        if (b == 0) return (v >>> 2) + (v >>> 5);
        return (v >>> 1) + (v >>> 3) + (v >>> 6);
    endfunction

    function automatic longint round_sat(longint s, output bit clipped);
        longint r;
        longint hi;
        hi = (longint'(1) <<< (OUT_W - 1)) - 1;
        r = (s + (longint'(1) <<< FRAC)) >>> (FRAC + 1);
        clipped = 1'b0;
        if (r > hi) begin r = hi; clipped = 1'b1; end
        else if (r < -hi - 1) begin r = -hi - 1; clipped = 1'b1; end
        return r;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 4; k++) m_x[k] = 0;
        for (int b = 0; b < 2; b++) begin m_y[b][0] = 0; m_y[b][1] = 0; end
        e_lp = 0;
        e_hp = 0;
    endtask

    task automatic model_step(longint x);
        longint yn [2];
        longint u_now;
        longint u_old;
        bit c0;
        bit c1;
        for (int b = 0; b < 2; b++) begin
            u_now = m_x[b] <<< FRAC;
            u_old = m_x[b + 2] <<< FRAC;
            yn[b] = coef_mul(b, u_now - m_y[b][1]) + u_old;
        end
        e_lp = round_sat(yn[0] + yn[1], c0);
        e_hp = round_sat(yn[0] - yn[1], c1);
        if (c0 || c1) clip_seen++;
        for (int b = 0; b < 2; b++) begin
            m_y[b][1] = m_y[b][0];
            m_y[b][0] = yn[b];
        end
        m_x[3] = m_x[2];
        m_x[2] = m_x[1];
        m_x[1] = m_x[0];
        m_x[0] = x;
    endtask

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_model(string tag);
        check(longint'(lp_out) == e_lp, {tag, " lp_out"}, longint'(lp_out), e_lp);
        check(longint'(hp_out) == e_hp, {tag, " hp_out"}, longint'(hp_out), e_hp);
    endtask

    // Drive one edge; the model follows the same edge; compare afterwards.
    task automatic drive(longint x, bit c, bit r, string tag, bit chk);
        @(negedge clk);
        din = IN_W'(x);
        ce  = c;
        rst = r;
        @(posedge clk);
        if (r) model_reset();
        else if (c) model_step(x);
        #1;
        if (chk) cmp_model(tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        longint prev_lp;
        longint prev_hp;
        bit     c;
        longint x;
        void'($urandom(32'h5eed_4b1d));
        model_reset();

        // R1: reset state
        for (int i = 0; i < 3; i++) drive(0, 1, 1, "R1", 1'b0);
        check(lp_out == '0, "R1 lp after reset", lp_out, 0);
        check(hp_out == '0, "R1 hp after reset", hp_out, 0);
        for (int i = 0; i < 6; i++) drive(0, 1, 0, "R1 zero input", 1'b1);

        // R2: latency of two enabled edges
        drive(1000, 1, 0, "R2", 1'b0);
        check(lp_out == '0, "R2 lp one edge after capture", lp_out, 0);
        drive(0, 1, 0, "R2", 1'b0);
        check(lp_out != '0, "R2 lp two edges after capture", lp_out, e_lp);
        cmp_model("R2 first response");
        for (int i = 0; i < 30; i++) drive(0, 1, 0, "R3 impulse tail", 1'b1);

        // R6: tiny values exercise the half-LSB rounding
        drive(0, 1, 1, "R6", 1'b0);
        for (int i = 0; i < 60; i++) begin
            x = longint'($urandom_range(6)) - 3;
            drive(x, 1, 0, "R6 rounding", 1'b1);
        end

        // R4: constant input
        drive(0, 1, 1, "R4", 1'b0);
        for (int i = 0; i < 300; i++) drive(12000, 1, 0, "R3 dc", 1'b1);
        check(hp_out >= -2 && hp_out <= 2, "R4 hp near zero", hp_out, 0);
        check(lp_out >= 11998 && lp_out <= 12002, "R4 lp near input", lp_out, 12000);

        // R5: alternating full scale
        drive(0, 1, 1, "R5", 1'b0);
        for (int i = 0; i < 300; i++)
            drive((i % 2 == 0) ? FS : -FS, 1, 0, "R3 nyquist", 1'b1);
        check(lp_out >= -2 && lp_out <= 2, "R5 lp near zero", lp_out, 0);
        check(hp_out >= 32760 || hp_out <= -32760, "R5 hp near full scale", hp_out, FS);

        // R7: abrupt pattern changes at full scale
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 40; i++) drive(FS, 1, 0, "R7 saturation", 1'b1);
            for (int i = 0; i < 40; i++)
                drive((i % 2 == 0) ? -FS : FS, 1, 0, "R7 saturation", 1'b1);
            for (int i = 0; i < 40; i++) drive(-FS - 1, 1, 0, "R7 saturation", 1'b1);
        end
        check(clip_seen > 0, "R7 clipping exercised", clip_seen, 1);

        // R8: random data with random enable
        for (int i = 0; i < 3000; i++) begin
            prev_lp = lp_out;
            prev_hp = hp_out;
            c = ($urandom_range(9) < 7);
            x = longint'($urandom_range(65535)) - 32768;
            if (i % 97 == 5) x = FS;
            drive(x, c, 0, c ? "R2 random" : "R8 enable low", 1'b1);
            if (!c) begin
                check(longint'(lp_out) == prev_lp, "R8 lp held", lp_out, prev_lp);
                check(longint'(hp_out) == prev_hp, "R8 hp held", hp_out, prev_hp);
            end
        end

        // R1: reset wins over a low enable
        drive(20000, 0, 1, "R1", 1'b0);
        check(lp_out == '0 && hp_out == '0, "R1 reset with ce low", lp_out, 0);
        for (int i = 0; i < 5; i++) drive(0, 1, 0, "R1 quiet after reset", 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule